// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Updates

This block is the purely combinational arithmetic and logic unit of a small accumulator-based processor core. Each cycle it takes an operation code, two 8-bit operands (`a_i`, normally the accumulator, and `b_i`, normally a memory or immediate value), the current carry flag and the current auxiliary-carry flag. It returns an 8-bit result together with next values for the carry, auxiliary-carry and overflow flags. It also returns one write enable per flag, which tells the surrounding status register which flags the operation is allowed to change.

The zero condition is a single output that always reflects the current result. The core uses it both as the next zero flag and as the decision for skip-if-zero style instructions. One shared adder serves addition, subtraction, increment and decrement. In subtraction the carry means that no borrow occurred, and the auxiliary carry follows the same inverted-borrow rule on the low nibble. Storage of the flags and sequencing of instructions belong to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: Opcodes are ADD=0, ADC=1, SUB=2, SBC=3, DAA=4, AND=5, OR=6, XOR=7, CPL=8, RL=9, RR=10, RLC=11, RRC=12, INC=13, DEC=14, reserved=15. The arithmetic result is the low 8 bits of A+B (ADD), A+B+Cin (ADC), A+~B+1 (SUB) and A+~B+Cin (SBC).
- R2: For ADD/ADC/SUB/SBC, `c_o` is the carry out of bit 7, so it is 1 for an addition overflow past 8 bits and 1 when a subtraction needs no borrow. `c_we_o` is 1.
- R3: For ADD/ADC/SUB/SBC, `ac_o` is the carry out of bit 3 of the same sum, so in subtraction it is 1 when no borrow reaches the low nibble. `ac_we_o` is 1.
- R4: For ADD/ADC/SUB/SBC, `ov_o` is 1 exactly when the carry into bit 7 differs from the carry out of bit 7 (signed overflow). `ov_we_o` is 1.
- R5: `res_zero_o` is 1 exactly when `res_o` is 00h, for every opcode. `z_we_o` is 1 for ADD, ADC, SUB, SBC, AND, OR, XOR, CPL, INC and DEC, and 0 otherwise.
- R6: AND, OR and XOR combine A with B bitwise. CPL returns ~A. INC returns A+1 and DEC returns A-1, both modulo 256. These six opcodes raise only `z_we_o`.
- R7: RL and RR rotate A by one bit left or right within 8 bits, and all four flag enables are 0.
- R8: RLC and RRC rotate the 9-bit value formed by A and Cin. The bit shifted out of A appears on `c_o`, and only `c_we_o` is 1.
- R9: DAA first adds 06h to A when A[3:0] > 9 or ACin = 1. It then adds 60h when the upper nibble of that intermediate is > 9, Cin = 1, or the first step carried out of bit 7. `c_o` is 1 exactly when the second correction is applied, and only `c_we_o` is 1.
- R10: Reserved opcode 15 returns A unchanged with all flag enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (R1 encoding) |
| a_i | input | 8 | First operand, normally the accumulator |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| res_o | output | 8 | Operation result |
| res_zero_o | output | 1 | Result equals zero; next zero flag and skip decision |
| c_o | output | 1 | Next carry flag value |
| ac_o | output | 1 | Next auxiliary-carry flag value |
| ov_o | output | 1 | Next overflow flag value |
| z_we_o | output | 1 | Zero flag update enable |
| c_we_o | output | 1 | Carry flag update enable |
| ac_we_o | output | 1 | Auxiliary-carry flag update enable |
| ov_we_o | output | 1 | Overflow flag update enable |

## Verification
Every output is combinational, so each result and flag is due in the same cycle in which the opcode and operands are applied, with zero register stages in between. The bench drives a new stimulus just after a rising clock edge and compares all outputs at the following falling edge, half a period later, when the logic has long settled. A flag value is compared only when its enable is expected to be set. The enables and the zero output are always compared.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_DAA = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_CPL = 4'd8,
    OP_RL  = 4'd9,
    OP_RR  = 4'd10,
    OP_RLC = 4'd11,
    OP_RRC = 4'd12,
    OP_INC = 4'd13,
    OP_DEC = 4'd14,
    OP_RSV = 4'd15
  } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         hcarry_o,
  output logic         ovf_o
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] b_eff;
  logic [W:0]   full_sum;
  logic [H:0]   low_sum;
  logic [W-1:0] msb_in_sum;

  always_comb begin
    b_eff      = sub_i ? ~b_i : b_i;
    full_sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
    low_sum    = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, cin_i};
    msb_in_sum = {1'b0, a_i[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, cin_i};
    sum_o      = full_sum[W-1:0];
    cout_o     = full_sum[W];
    hcarry_o   = low_sum[H];
    ovf_o      = msb_in_sum[W-1] ^ full_sum[W];
  end

  // R2: a full subtraction carries out exactly when no borrow is needed
  always_comb begin
    if (sub_i && cin_i) begin
      p_sub_noborrow_r2: assert (cout_o == (a_i >= b_i))
        else $error("subtract carry disagrees with operand order");
    end
  end

endmodule

// File: rtl/alu8_rot.sv
module alu8_rot #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  logic         left_i,
  input  logic         thru_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic fill_bit;

  always_comb begin
    if (left_i) begin
      fill_bit = thru_i ? cin_i : a_i[W-1];
      res_o    = {a_i[W-2:0], fill_bit};
      cout_o   = a_i[W-1];
    end else begin
      fill_bit = thru_i ? cin_i : a_i[0];
      res_o    = {fill_bit, a_i[W-1:1]};
      cout_o   = a_i[0];
    end
  end

  // R7: a plain rotate keeps the population count of the operand
  always_comb begin
    if (!thru_i) begin
      p_rot_popcount_r7: assert ($countones(res_o) == $countones(a_i))
        else $error("plain rotate lost or gained a bit");
    end
  end

endmodule

// File: rtl/alu8_daa.sv
module alu8_daa #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         c_i,
  input  logic         ac_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  localparam int unsigned H = W / 2;
  localparam logic [H-1:0] DIGIT_MAX = H'(9);
  localparam logic [W:0]   LO_ADJ    = (W+1)'(6);
  localparam logic [W-1:0] HI_ADJ    = W'(6) << H;

  logic         lo_fix;
  logic         hi_fix;
  logic [W:0]   step1;

  always_comb begin
    lo_fix = (a_i[H-1:0] > DIGIT_MAX) | ac_i;
    step1  = {1'b0, a_i} + (lo_fix ? LO_ADJ : '0);
    hi_fix = (step1[W-1:H] > DIGIT_MAX) | c_i | step1[W];
    res_o  = step1[W-1:0] + (hi_fix ? HI_ADJ : '0);
    c_o    = hi_fix;
  end

  // R9: an incoming carry always forces the high correction
  always_comb begin
    if (c_i) begin
      p_daa_keep_carry_r9: assert (c_o)
        else $error("decimal adjust dropped the incoming carry");
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            c_i,
  input  logic            ac_i,
  output logic [W-1:0]    res_o,
  output logic            res_zero_o,
  output logic            c_o,
  output logic            ac_o,
  output logic            ov_o,
  output logic            z_we_o,
  output logic            c_we_o,
  output logic            ac_we_o,
  output logic            ov_we_o
);
  alu_op_e op;

  logic [W-1:0] add_b;
  logic         add_sub;
  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         add_hc;
  logic         add_ov;

  logic         rot_left;
  logic         rot_thru;
  logic [W-1:0] rot_res;
  logic         rot_cout;

  logic [W-1:0] daa_res;
  logic         daa_c;

  assign op = alu_op_e'(op_i);

  // operand steering for the shared adder
  always_comb begin
    add_b   = b_i;
    add_sub = 1'b0;
    add_cin = 1'b0;
    unique case (op)
      OP_ADC: add_cin = c_i;
      OP_SUB: begin add_sub = 1'b1; add_cin = 1'b1; end
      OP_SBC: begin add_sub = 1'b1; add_cin = c_i;  end
      OP_INC: begin add_b = '0; add_cin = 1'b1; end
      OP_DEC: begin add_b = '0; add_sub = 1'b1; end
      default: ;
    endcase
    rot_left = (op == OP_RL)  || (op == OP_RLC);
    rot_thru = (op == OP_RLC) || (op == OP_RRC);
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a_i      (a_i),
    .b_i      (add_b),
    .sub_i    (add_sub),
    .cin_i    (add_cin),
    .sum_o    (add_sum),
    .cout_o   (add_cout),
    .hcarry_o (add_hc),
    .ovf_o    (add_ov)
  );

  alu8_rot #(.W(W)) u_rot (
    .a_i    (a_i),
    .cin_i  (c_i),
    .left_i (rot_left),
    .thru_i (rot_thru),
    .res_o  (rot_res),
    .cout_o (rot_cout)
  );

  alu8_daa #(.W(W)) u_daa (
    .a_i  (a_i),
    .c_i  (c_i),
    .ac_i (ac_i),
    .res_o(daa_res),
    .c_o  (daa_c)
  );

  // result select and flag update enables
  always_comb begin
    res_o   = a_i;
    c_o     = add_cout;
    ac_o    = add_hc;
    ov_o    = add_ov;
    z_we_o  = 1'b0;
    c_we_o  = 1'b0;
    ac_we_o = 1'b0;
    ov_we_o = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res_o   = add_sum;
        z_we_o  = 1'b1;
        c_we_o  = 1'b1;
        ac_we_o = 1'b1;
        ov_we_o = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res_o  = add_sum;
        z_we_o = 1'b1;
      end
      OP_DAA: begin
        res_o  = daa_res;
        c_o    = daa_c;
        c_we_o = 1'b1;
      end
      OP_AND: begin res_o = a_i & b_i; z_we_o = 1'b1; end
      OP_OR:  begin res_o = a_i | b_i; z_we_o = 1'b1; end
      OP_XOR: begin res_o = a_i ^ b_i; z_we_o = 1'b1; end
      OP_CPL: begin res_o = ~a_i;      z_we_o = 1'b1; end
      OP_RL, OP_RR: res_o = rot_res;
      OP_RLC, OP_RRC: begin
        res_o  = rot_res;
        c_o    = rot_cout;
        c_we_o = 1'b1;
      end
      default: ;
    endcase
    res_zero_o = (res_o == '0);
  end

  // assertions relating the opcode port to the selected unit outputs
  always_comb begin
    if (op == OP_ADD) begin
      p_add_sum_r1: assert ({c_o, res_o} == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("ADD result or carry wrong");
    end
    if (op == OP_RL || op == OP_RR) begin
      p_rot_no_flags_r7: assert (!z_we_o && !c_we_o && !ac_we_o && !ov_we_o)
        else $error("plain rotate enabled a flag write");
    end
    if (op == OP_RLC) begin
      p_rlc_carry_r8: assert (c_o == a_i[W-1] && res_o[0] == c_i)
        else $error("RLC did not move the carry");
    end
    if (op == OP_INC || op == OP_DEC || op == OP_AND || op == OP_OR) begin
      p_only_zero_r6: assert (z_we_o && !c_we_o && !ac_we_o && !ov_we_o)
        else $error("logic or step opcode touched a non-zero flag");
    end
    if (op == OP_RSV) begin
      p_rsv_passthru_r10: assert (res_o == a_i && !z_we_o && !c_we_o)
        else $error("reserved opcode altered state");
    end
  end

endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb_top;

  logic       clk;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] a;
  logic [7:0] b;
  logic       cin;
  logic       acin;
  logic [7:0] res;
  logic       zero, c_n, ac_n, ov_n, zwe, cwe, acwe, ovwe;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  alu8_core dut_i (
    .op_i      (op),
    .a_i       (a),
    .b_i       (b),
    .c_i       (cin),
    .ac_i      (acin),
    .res_o     (res),
    .res_zero_o(zero),
    .c_o       (c_n),
    .ac_o      (ac_n),
    .ov_o      (ov_n),
    .z_we_o    (zwe),
    .c_we_o    (cwe),
    .ac_we_o   (acwe),
    .ov_we_o   (ovwe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // packed layout: [15:8] result, 7 zero, 6 c, 5 ac, 4 ov, 3 zwe, 2 cwe, 1 acwe, 0 ovwe
  function automatic logic [15:0] ref_model(input int o, input int x, input int y,
                                            input int ci_in, input int aci_in);
    int r = 0, bb = 0, ci = 0, s = 0, t = 0;
    bit fz = 0, fc = 0, fa = 0, fo = 0, wz = 0, wc = 0, wa = 0, wo = 0;
    case (o)
      0, 1, 2, 3: begin
        bb = (o >= 2) ? ((~y) & 255) : y;
        ci = (o == 0) ? 0 : ((o == 2) ? 1 : ci_in);
        s  = x + bb + ci;
        r  = s & 255;
        fc = (s > 255);
        fa = (((x & 15) + (bb & 15) + ci) > 15);
        fo = (((x >> 7) & 1) == ((bb >> 7) & 1)) && (((r >> 7) & 1) != ((x >> 7) & 1));
        wz = 1; wc = 1; wa = 1; wo = 1;
      end
      4: begin
        t = x;
        if ((x & 15) > 9 || aci_in != 0) t = t + 6;
        fc = (((t >> 4) & 15) > 9) || (ci_in != 0) || (t > 255);
        if (fc) t = t + 96;
        r = t & 255;
        wc = 1;
      end
      5:  begin r = x & y; wz = 1; end
      6:  begin r = x | y; wz = 1; end
      7:  begin r = x ^ y; wz = 1; end
      8:  begin r = (~x) & 255; wz = 1; end
      9:  r = ((x << 1) | (x >> 7)) & 255;
      10: r = ((x >> 1) | ((x & 1) << 7)) & 255;
      11: begin r = ((x << 1) | ci_in) & 255; fc = (x >> 7) & 1; wc = 1; end
      12: begin r = (x >> 1) | (ci_in << 7); fc = x & 1; wc = 1; end
      13: begin r = (x + 1) & 255; wz = 1; end
      14: begin r = (x + 255) & 255; wz = 1; end
      default: r = x;
    endcase
    fz = (r == 0);
    return {r[7:0], fz, fc, fa, fo, wz, wc, wa, wo};
  endfunction

  function automatic logic [15:0] got_vec();
    return {res, zero, c_n, ac_n, ov_n, zwe, cwe, acwe, ovwe};
  endfunction

  task automatic compare(input string tag, input logic [15:0] exp);
    logic [15:0] mask;
    logic [15:0] got;
    mask = {8'hFF, 1'b1, exp[2], exp[1], exp[0], 4'hF};
    got  = got_vec();
    n_checks++;
    if ((got & mask) !== (exp & mask)) begin
      n_fails++;
      $display("FAIL %s op=%0d a=%h b=%h c=%b ac=%b : actual=%h expected=%h",
               tag, op, a, b, cin, acin, got & mask, exp & mask);
    end
  endtask

  task automatic apply(input int o, input int x, input int y, input int ci, input int aci);
    @(posedge clk);
    op = 4'(o); a = 8'(x); b = 8'(y); cin = 1'(ci); acin = 1'(aci);
    @(negedge clk);
  endtask

  task automatic vec(input string tag, input int o, input int x, input int y,
                     input int ci, input int aci);
    apply(o, x, y, ci, aci);
    compare(tag, ref_model(o, x, y, ci, aci));
  endtask

  task automatic hand(input string tag, input int o, input int x, input int y,
                      input int ci, input int aci, input logic [15:0] exp);
    apply(o, x, y, ci, aci);
    compare(tag, exp);
  endtask

  task automatic t_idle();
    // R5: all-zero inputs after reset give a zero result with full enables
    hand("R5 idle", 0, 0, 0, 0, 0, {8'h00, 4'b1000, 4'b1111});
  endtask

  task automatic t_add_corners();
    hand("R3 ADD half carry", 0, 8'h0F, 8'h01, 0, 0, {8'h10, 4'b0010, 4'b1111});
    hand("R4 ADD signed ovf", 0, 8'h7F, 8'h01, 0, 0, {8'h80, 4'b0011, 4'b1111});
    hand("R2 ADD carry out",  0, 8'h80, 8'h80, 0, 0, {8'h00, 4'b1101, 4'b1111});
    hand("R1 ADC wrap",       1, 8'hFF, 8'h00, 1, 0, {8'h00, 4'b1110, 4'b1111});
  endtask

  task automatic t_sub_corners();
    hand("R2 SUB equal no borrow", 2, 8'h05, 8'h05, 0, 0, {8'h00, 4'b1110, 4'b1111});
    hand("R3 SUB borrow",          2, 8'h03, 8'h05, 1, 0, {8'hFE, 4'b0000, 4'b1111});
    hand("R1 SBC with borrow in",  3, 8'h05, 8'h05, 0, 0, {8'hFF, 4'b0000, 4'b1111});
  endtask

  task automatic t_arith_sweep();
    for (int o = 0; o < 4; o++)
      for (int x = 0; x < 256; x += 37)
        for (int y = 3; y < 256; y += 41)
          for (int ci = 0; ci < 2; ci++)
            vec("R1 R2 R3 R4 sweep", o, x, y, ci, 0);
  endtask

  task automatic t_logic();
    hand("R6 AND to zero",  5, 8'hF0, 8'h0F, 1, 1, {8'h00, 4'b1000, 4'b1000});
    hand("R6 CPL to zero",  8, 8'hFF, 8'h00, 0, 0, {8'h00, 4'b1000, 4'b1000});
    hand("R6 INC wrap",    13, 8'hFF, 8'h00, 0, 0, {8'h00, 4'b1000, 4'b1000});
    hand("R6 DEC wrap",    14, 8'h00, 8'h00, 1, 0, {8'hFF, 4'b0000, 4'b1000});
    for (int o = 5; o < 9; o++)
      for (int x = 1; x < 256; x += 51)
        vec("R6 logic sweep", o, x, x ^ 8'h5A, 0, 0);
  endtask

  task automatic t_rotates();
    hand("R7 RL",  9, 8'h81, 8'h00, 0, 0, {8'h03, 4'b0000, 4'b0000});
    hand("R7 RR", 10, 8'h01, 8'h00, 1, 0, {8'h80, 4'b0000, 4'b0000});
    hand("R8 RLC",11, 8'h80, 8'h00, 0, 0, {8'h00, 4'b1100, 4'b0100});
    hand("R8 RRC",12, 8'h01, 8'h00, 1, 0, {8'h80, 4'b0100, 4'b0100});
    for (int o = 9; o < 13; o++)
      for (int x = 0; x < 256; x += 29)
        for (int ci = 0; ci < 2; ci++)
          vec("R7 R8 rotate sweep", o, x, 0, ci, 0);
  endtask

  task automatic t_daa();
    hand("R9 DAA both fix",   4, 8'h9A, 0, 0, 0, {8'h00, 4'b1100, 4'b0100});
    hand("R9 DAA ac fix",     4, 8'h12, 0, 0, 1, {8'h18, 4'b0000, 4'b0100});
    hand("R9 DAA carry fix",  4, 8'h99, 0, 1, 0, {8'hF9, 4'b0100, 4'b0100});
    hand("R9 DAA no fix",     4, 8'h15, 0, 0, 0, {8'h15, 4'b0000, 4'b0100});
    hand("R9 DAA step carry", 4, 8'hFF, 0, 0, 0, {8'h65, 4'b0100, 4'b0100});
    for (int x = 0; x < 256; x += 7)
      for (int f = 0; f < 4; f++)
        vec("R9 DAA sweep", 4, x, 0, f & 1, f >> 1);
  endtask

  task automatic t_reserved();
    hand("R10 reserved pass", 15, 8'hA5, 8'h3C, 1, 1, {8'hA5, 4'b0000, 4'b0000});
    hand("R10 reserved zero", 15, 8'h00, 8'hFF, 1, 1, {8'h00, 4'b1000, 4'b0000});
  endtask

  initial begin
    rst_n = 1'b0;
    op = '0; a = '0; b = '0; cin = 1'b0; acin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_add_corners();
    t_sub_corners();
    t_arith_sweep();
    t_logic();
    t_rotates();
    t_daa();
    t_reserved();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule